// File: doc/BRIEF.md
# Periodic Interrupt and Pulse Generator

This block drives an active-low output pin from the carry strobes of a real-time-clock counter chain. Software picks one of three periods: once per second, once per minute or once per hour. On each event at that period the pin goes low and a status flag goes to 1. The flag is always the inverse of the pin. A mask bit stops events from reaching the pin.

There are two output modes, and they share the flag. In latched mode the pin stays low until software writes 0 to the flag, and events that arrive while the flag is set are dropped. In pulse mode the pin also returns high by itself after 256 periods of the 32.768 kHz tick enable, which is 7.8125 ms. Software can still end the pulse early by writing 0 to the flag.

The block has a two-register write/read interface. Address 0 holds the status flag. Address 1 holds the configuration. The counter chain and the bus decode sit outside this block.

Top module: `periodic_irq_gen`

## Requirements
- R1: After reset the pin is high and the flag reads 0. The configuration register (address 1) reads 4'b0001: bit 0 is mask = 1, bit 1 is mode = 0, and bits 3:2 are the period select = 00.
- R2: The period select in configuration bits 3:2 chooses the event source. 01 uses the second strobe, 10 the minute strobe and 11 the hour strobe. A strobe that is not selected has no effect. An accepted event drives the pin low on the clock edge after the strobe.
- R3: When the period select is 00, no strobe produces an event.
- R4: When the mask bit (configuration bit 0) is 1, events do not drive the pin. Setting the mask does not clear a flag that is already set.
- R5: Bit 0 of the status register (address 0) always reads as the inverse of the pin. Bits 3:1 of the status register read 0.
- R6: Configuration bit 1 selects the mode. With mode = 1 (latched), a set flag stays set until software writes 0 to status bit 0.
- R7: An event that arrives while the flag is 1 is ignored. It is not queued, so the pin stays high after software clears the flag.
- R8: With mode = 0 (pulse), the flag clears by itself on the 256th tick-enable cycle after the event edge.
- R9: Writing 0 to status bit 0 clears the flag on the next edge, in either mode.
- R10: Writing 1 to status bit 0 leaves the flag unchanged.
- R11: A configuration write that changes the mode or the mask cancels a running pulse timer, and the flag then stays set until software clears it. A configuration write that changes neither bit leaves the timer running.
- R12: If a write of 0 to the flag arrives in the same cycle as an event, the clear wins and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable at 32.768 kHz |
| sec_stb | input | 1 | One-cycle seconds carry strobe |
| min_stb | input | 1 | One-cycle minutes carry strobe |
| hour_stb | input | 1 | One-cycle hours carry strobe |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 is status, 1 is configuration |
| wr_data | input | 4 | Write data |
| rd_data | output | 4 | Read data for the register selected by reg_addr |
| irq_n | output | 1 | Active-low interrupt or pulse output |

## Verification
The hardest case to reach is a pulse-mode flag whose timer has been cancelled by a configuration write. Reaching it needs an accepted event, a partial count of tick enables, and then a write that changes only the mode or only the mask. Directed sequences build this case, along with a configuration write that changes neither bit and a clear that arrives in the same cycle as an event. Random stimulus then runs with tick enables dense enough that a pulse can expire while strobes and writes are still arriving. The result is compared every cycle against a reference model in the bench.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int REG_W = 4;

    typedef enum logic [1:0] {
        PER_OFF  = 2'b00,
        PER_SEC  = 2'b01,
        PER_MIN  = 2'b10,
        PER_HOUR = 2'b11
    } period_e;

    typedef enum logic {
        MODE_PULSE = 1'b0,
        MODE_LATCH = 1'b1
    } mode_e;

    typedef enum logic {
        ADDR_STATUS = 1'b0,
        ADDR_CONFIG = 1'b1
    } addr_e;

    typedef struct packed {
        period_e period;
        mode_e   mode;
        logic    mask;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{period: PER_OFF, mode: MODE_PULSE, mask: 1'b1};
endpackage

// File: rtl/pit_event_sel.sv
module pit_event_sel
    import pit_pkg::*;
(
    input  cfg_t cfg,
    input  logic sec_stb,
    input  logic min_stb,
    input  logic hour_stb,
    output logic evt
);
    logic raw;

    always_comb begin
        case (cfg.period)
            PER_SEC:  raw = sec_stb;
            PER_MIN:  raw = min_stb;
            PER_HOUR: raw = hour_stb;
            default:  raw = 1'b0;
        endcase
        evt = raw && !cfg.mask;
    end
endmodule

// File: rtl/pit_cfg_reg.sv
module pit_cfg_reg
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cfg,
    input  logic [REG_W-1:0] wr_data,
    output cfg_t             cfg_q,
    output logic             restart
);
    cfg_t cfg_d;
    cfg_t wr_val;

    always_comb begin
        wr_val.period = period_e'(wr_data[3:2]);
        wr_val.mode   = mode_e'(wr_data[1]);
        wr_val.mask   = wr_data[0];
        cfg_d   = cfg_q;
        restart = 1'b0;
        if (wr_cfg) begin
            cfg_d   = wr_val;
            restart = (wr_val.mode != cfg_q.mode) || (wr_val.mask != cfg_q.mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/pit_pulse_timer.sv
module pit_pulse_timer #(
    parameter int TICKS = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic start,
    input  logic abort,
    output logic expire
);
    localparam int CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TICKS - 1);

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (abort) begin
            st_d.active = 1'b0;
        end else if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = LOAD;
        end else if (st_q.active && tick_en) begin
            if (st_q.cnt == '0) begin
                expire      = 1'b1;
                st_d.active = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pit_pkg::*;
#(
    parameter int PULSE_TICKS = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             sec_stb,
    input  logic             min_stb,
    input  logic             hour_stb,
    input  logic             wr_en,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq_n
);
    cfg_t cfg_q;
    logic cfg_restart;
    logic evt_w;
    logic expire_w;
    logic sw_clr;
    logic accept;
    logic flag_d, flag_q;

    pit_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cfg  (wr_en && (reg_addr == ADDR_CONFIG)),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .restart (cfg_restart)
    );

    pit_event_sel u_sel (
        .cfg      (cfg_q),
        .sec_stb  (sec_stb),
        .min_stb  (min_stb),
        .hour_stb (hour_stb),
        .evt      (evt_w)
    );

    pit_pulse_timer #(.TICKS(PULSE_TICKS)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .start   (accept && (cfg_q.mode == MODE_PULSE)),
        .abort   (sw_clr || cfg_restart),
        .expire  (expire_w)
    );

    always_comb begin
        sw_clr = wr_en && (reg_addr == ADDR_STATUS) && !wr_data[0];
        accept = evt_w && !flag_q && !sw_clr;
        flag_d = flag_q;
        if (accept)                flag_d = 1'b1;
        else if (sw_clr || expire_w) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    always_comb begin
        irq_n = !flag_q;
        if (reg_addr == ADDR_CONFIG) rd_data = cfg_q;
        else                         rd_data = {{(REG_W-1){1'b0}}, flag_q};
    end
endmodule

// File: rtl/pit_chk.sv
module pit_chk
    import pit_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             irq_n,
    input logic             tick_en,
    input logic             wr_en,
    input logic             reg_addr,
    input logic [REG_W-1:0] wr_data,
    input logic             evt,
    input cfg_t             cfg
);
    logic clr_wr, one_wr;
    assign clr_wr = wr_en && (reg_addr == ADDR_STATUS) && !wr_data[0];
    assign one_wr = wr_en && (reg_addr == ADDR_STATUS) && wr_data[0];

    // R2
    fall_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(evt));
    // R3
    fall_needs_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> ($past(cfg.period) != PER_OFF));
    // R4
    fall_needs_unmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> !$past(cfg.mask));
    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && cfg.mode == MODE_LATCH && !clr_wr) |=> !irq_n);
    // R9
    clear_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> irq_n);
    // R10
    write_one_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && one_wr && !tick_en) |=> !irq_n);
endmodule

bind periodic_irq_gen pit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_n    (irq_n),
    .tick_en  (tick_en),
    .wr_en    (wr_en),
    .reg_addr (reg_addr),
    .wr_data  (wr_data),
    .evt      (evt_w),
    .cfg      (cfg_q)
);

// File: tb/periodic_irq_gen_bench.sv
module periodic_irq_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0, sec_stb = 1'b0, min_stb = 1'b0, hour_stb = 1'b0;
    logic       wr_en = 1'b0, reg_addr = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic [3:0] rd_data;
    logic       irq_n;

    int checks = 0, failures = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    // reference model
    bit m_flag = 1'b0, m_act = 1'b0, m_mask = 1'b1, m_mode = 1'b0;
    bit [1:0] m_sel = 2'b00;
    int m_cnt = 0;

    always #4 clk = ~clk;

    periodic_irq_gen u_periodic_irq_gen (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sec_stb(sec_stb),
        .min_stb(min_stb), .hour_stb(hour_stb), .wr_en(wr_en),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n)
    );

    function automatic bit [3:0] exp_rd(bit a);
        return a ? {m_sel, m_mode, m_mask} : {3'b000, m_flag};
    endfunction

    task automatic expect4(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_step();
        bit clr, chg, ev, acc, nf, nact;
        int ncnt;
        clr = wr_en && !reg_addr && !wr_data[0];
        chg = wr_en && reg_addr && ((wr_data[0] != m_mask) || (wr_data[1] != m_mode));
        ev  = !m_mask && ((m_sel == 2'b01 && sec_stb) || (m_sel == 2'b10 && min_stb) ||
                          (m_sel == 2'b11 && hour_stb));
        acc = ev && !m_flag && !clr;
        nf = m_flag; nact = m_act; ncnt = m_cnt;
        if (m_act && tick_en) begin
            if (m_cnt == 0) begin nf = 1'b0; nact = 1'b0; end
            else ncnt = m_cnt - 1;
        end
        if (clr) begin nf = 1'b0; nact = 1'b0; end
        if (acc) begin
            nf = 1'b1;
            if (!m_mode && !chg) begin nact = 1'b1; ncnt = 255; end
        end
        if (chg) nact = 1'b0;
        if (wr_en && reg_addr) begin
            m_sel = wr_data[3:2]; m_mode = wr_data[1]; m_mask = wr_data[0];
        end
        m_flag = nf; m_act = nact; m_cnt = ncnt;
    endtask

    task automatic cyc(bit t, bit s, bit mi, bit h, bit w, bit a, bit [3:0] d);
        tick_en = t; sec_stb = s; min_stb = mi; hour_stb = h;
        wr_en = w; reg_addr = a; wr_data = d;
        model_step();
        @(posedge clk);
        @(negedge clk);
        tick_en = 0; sec_stb = 0; min_stb = 0; hour_stb = 0; wr_en = 0;
        #1;
        expect4({cur_tag, " pin"}, {3'b000, irq_n}, {3'b000, !m_flag});
        expect4({cur_tag, " read"}, rd_data, exp_rd(a));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 1'b0, 4'h0);
    endtask
    task automatic ticks(int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 1'b0, 4'h0);
    endtask
    task automatic wcfg(bit [3:0] d);  cyc(0, 0, 0, 0, 1, 1'b1, d); endtask
    task automatic wflag(bit v);       cyc(0, 0, 0, 0, 1, 1'b0, {3'b000, v}); endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        expect4("R1 pin", {3'b000, irq_n}, 4'b0001);
        reg_addr = 1'b1; #1;
        expect4("R1 cfg", rd_data, 4'b0001);
        reg_addr = 1'b0; #1;
        expect4("R1 flag", rd_data, 4'b0000);

        // R2 second period, latched
        cur_tag = "R2";
        wcfg(4'b0110);
        cyc(0, 0, 1, 1, 0, 1'b0, 4'h0);
        expect4("R2 unselected", {3'b000, irq_n}, 4'b0001);
        cyc(0, 1, 0, 0, 0, 1'b0, 4'h0);
        expect4("R2 sec event", {3'b000, irq_n}, 4'b0000);
        cur_tag = "R5";
        expect4("R5 flag read", rd_data, 4'b0001);
        cur_tag = "R6";
        ticks(300);
        expect4("R6 latched hold", {3'b000, irq_n}, 4'b0000);
        cur_tag = "R10";
        wflag(1'b1);
        expect4("R10 write one", {3'b000, irq_n}, 4'b0000);
        cur_tag = "R7";
        cyc(0, 1, 0, 0, 0, 1'b0, 4'h0);
        wflag(1'b0);
        expect4("R7 not queued", {3'b000, irq_n}, 4'b0001);
        idle(3);
        expect4("R7 stays high", {3'b000, irq_n}, 4'b0001);

        // R2 minute and hour
        cur_tag = "R2";
        wcfg(4'b1010);
        cyc(0, 1, 0, 1, 0, 1'b0, 4'h0);
        expect4("R2 min unselected", {3'b000, irq_n}, 4'b0001);
        cyc(0, 0, 1, 0, 0, 1'b0, 4'h0);
        expect4("R2 min event", {3'b000, irq_n}, 4'b0000);
        wflag(1'b0);
        wcfg(4'b1110);
        cyc(0, 0, 1, 1, 0, 1'b0, 4'h0);
        expect4("R2 hour event", {3'b000, irq_n}, 4'b0000);

        // R4 mask keeps existing flag and blocks new events
        cur_tag = "R4";
        wcfg(4'b1111);
        expect4("R4 flag kept", {3'b000, irq_n}, 4'b0000);
        wflag(1'b0);
        cyc(0, 1, 1, 1, 0, 1'b0, 4'h0);
        expect4("R4 masked", {3'b000, irq_n}, 4'b0001);

        // R3 period off
        cur_tag = "R3";
        wcfg(4'b0010);
        cyc(0, 1, 1, 1, 0, 1'b0, 4'h0);
        expect4("R3 off", {3'b000, irq_n}, 4'b0001);

        // R12 clear and event same cycle
        cur_tag = "R12";
        wcfg(4'b0110);
        cyc(0, 1, 0, 0, 1, 1'b0, 4'h0);
        expect4("R12 clear wins", {3'b000, irq_n}, 4'b0001);

        // R8 pulse expiry after 256 ticks
        cur_tag = "R8";
        wcfg(4'b0100);
        cyc(0, 1, 0, 0, 0, 1'b0, 4'h0);
        ticks(255);
        expect4("R8 before expiry", {3'b000, irq_n}, 4'b0000);
        ticks(1);
        expect4("R8 expired", {3'b000, irq_n}, 4'b0001);

        // R9 early clear
        cur_tag = "R9";
        cyc(0, 1, 0, 0, 0, 1'b0, 4'h0);
        ticks(10);
        wflag(1'b0);
        expect4("R9 early clear", {3'b000, irq_n}, 4'b0001);

        // R11 same-value config write keeps timer running
        cur_tag = "R11";
        cyc(0, 1, 0, 0, 0, 1'b0, 4'h0);
        ticks(100);
        wcfg(4'b0100);
        ticks(156);
        expect4("R11 unchanged cfg expires", {3'b000, irq_n}, 4'b0001);
        // R11 mode change cancels timer
        cyc(0, 1, 0, 0, 0, 1'b0, 4'h0);
        ticks(10);
        wcfg(4'b0110);
        wcfg(4'b0100);
        ticks(400);
        expect4("R11 cancelled stays low", {3'b000, irq_n}, 4'b0000);
        wflag(1'b0);
        expect4("R11 sw clear", {3'b000, irq_n}, 4'b0001);

        // random phase against the model (R8 and mode mix)
        cur_tag = "R8 random";
        for (int i = 0; i < 6000; i++) begin
            bit t, s, mi, h, w, a;
            bit [3:0] d;
            t  = ($urandom % 3) == 0;
            s  = ($urandom % 40) == 0;
            mi = ($urandom % 40) == 0;
            h  = ($urandom % 40) == 0;
            w  = ($urandom % 60) == 0;
            a  = $urandom % 2;
            d  = 4'($urandom);
            if (a && (($urandom % 2) == 0)) d[0] = 1'b0;
            cyc(t, s, mi, h, w, a, d);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule